// File: doc/BRIEF.md
# Register-Mapped Serial Flash Master

This block is a serial-peripheral master for a single serial flash device, controlled through a small 32-bit register bus. Software queues transmit words into a four-word transmit queue, writes a control word that carries the transfer length, the clock/data phase options, the enables and a start bit, and then collects the received word from a four-word receive queue. Each start moves one word of 1 to 32 bits. The most significant selected bit goes out first, and the incoming bits are captured in parallel.

The serial clock is derived from the system clock by a divider value presented on an input port. The chip-select line is active low. Software can either drive it directly through a control bit or leave it to follow the transfer. Status reports live activity and queue levels, plus sticky completion and error flags that software clears by writing ones. Two status bits empty the queues on request.

Top module: `spi_flash_master`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0x0280_0000 (only receive-empty bit 25 and transmit-empty bit 23 set), the control word (offset 0x00) reads 0, `cs_n` is 1, and `sclk` and `mosi` are 0.
- R2: Control bits [4:0] hold length-1. A started transfer of N bits makes exactly 2N `sclk` transitions, and the last one occurs 2N×(`div`+1) clock cycles after the start edge.
- R3: The transmit word is right-aligned. Bit N-1 goes out first on `mosi`, and received bits shift in from bit 0 upward, so the last sampled bit lands in bit 0 and bits N and above are 0. With `miso` looped back to `mosi`, the received word equals the sent word masked to N bits.
- R4: Control field [27:26]=1 selects an idle-high `sclk`, and any other value selects idle-low. Field [19:18]=1 selects sampling on the second edge, with `mosi` held at 0 until the first edge. Otherwise bit N-1 is on `mosi` from the start edge and sampling happens on the first edge.
- R5: Writing 1 to control bit 30 while idle starts a transfer and pops the transmit queue. The same write while a transfer is running starts nothing and pops nothing.
- R6: With control bit 15 (transmit enable) at 0, zeros are shifted out and the transmit queue is not popped. With bit 14 (receive enable) at 0, no word is pushed into the receive queue.
- R7: With control bit 12 at 1, `cs_n` is the inverse of control bit 13. With bit 12 at 0, `cs_n` is low exactly while a transfer runs.
- R8: Status bit 31 is 1 only during a transfer. Status bit 30 sets when a transfer completes and stays set until a status write with bit 30 at 1.
- R9: A write to the transmit port (0x10) while the queue is full drops the word and sets status bit 26. A read of the receive port (0x20) while it is empty returns 0 and sets status bit 27. Both bits clear only on a status write with a 1 in that position.
- R10: A status write with bit 29 at 1 empties the receive queue, and one with bit 28 at 1 empties the transmit queue.
- R11: Each queue holds 4 words. Status bits 25, 24, 23 and 22 report, live, receive empty, receive full, transmit empty and transmit full.
- R12: A register read returns its data on `bus_rdata` from the clock edge that samples `bus_rd`. A read of the receive port pops one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div | input | DIV_W | Divider value; sclk half period is div+1 clocks |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong bit counter or divider shows up at once on `sclk`: the number of transitions or the position of the last one moves within the first transfer. A shift register that is misaligned or runs in the wrong direction shows up only when the word is read back from the receive port, one bus read after completion, so the looped-back data compare carries that check. Errors in the queue pointers or the sticky flags show up in the very next status read, as wrong level bits or as flags that fail to set or to clear.

// File: rtl/spiflash_pkg.sv
package spiflash_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = $clog2(WORD_W);

    // register offsets (bytes)
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_TXD  = 8'h10;
    localparam logic [7:0] OFS_RXD  = 8'h20;

    // control word bit positions
    localparam int C_START  = 30;
    localparam int C_POL_LO = 26;
    localparam int C_PHA_LO = 18;
    localparam int C_TXEN   = 15;
    localparam int C_RXEN   = 14;
    localparam int C_CSLVL  = 13;
    localparam int C_CSMAN  = 12;

    // status word bit positions
    localparam int S_BUSY   = 31;
    localparam int S_DONE   = 30;
    localparam int S_RXDROP = 29;
    localparam int S_TXDROP = 28;
    localparam int S_UNDER  = 27;
    localparam int S_OVER   = 26;
    localparam int S_RXEMP  = 25;
    localparam int S_RXFUL  = 24;
    localparam int S_TXEMP  = 23;
    localparam int S_TXFUL  = 22;

    typedef struct packed {
        logic [LEN_W-1:0] len_m1;
        logic             late_smp;
        logic             idle_hi;
        logic             tx_on;
        logic             rx_on;
        logic             cs_man;
        logic             cs_lvl;
    } ctrl_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;

    function automatic ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.len_m1   = w[LEN_W-1:0];
        c.late_smp = (w[C_PHA_LO+1:C_PHA_LO] == 2'd1);
        c.idle_hi  = (w[C_POL_LO+1:C_POL_LO] == 2'd1);
        c.tx_on    = w[C_TXEN];
        c.rx_on    = w[C_RXEN];
        c.cs_man   = w[C_CSMAN];
        c.cs_lvl   = w[C_CSLVL];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_pack(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LEN_W-1:0] = c.len_m1;
        w[C_PHA_LO]  = c.late_smp;
        w[C_POL_LO]  = c.idle_hi;
        w[C_TXEN]    = c.tx_on;
        w[C_RXEN]    = c.rx_on;
        w[C_CSMAN]   = c.cs_man;
        w[C_CSLVL]   = c.cs_lvl;
        return w;
    endfunction

endpackage

// File: rtl/spiflash_fifo.sv
module spiflash_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end
endmodule

// File: rtl/spiflash_shifter.sv
module spiflash_shifter
    import spiflash_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  ctrl_t             cfg,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int EW = LEN_W + 1;

    eng_state_t        st;
    logic [DIV_W-1:0]  cnt;
    logic [EW-1:0]     eidx;
    logic [LEN_W-1:0]  len_q;
    logic              late_q;
    logic [WORD_W-1:0] sh, rx_q, aligned;
    logic              tick, leading, last_edge, smp_edge;

    assign aligned   = tx_word << (LEN_W'(WORD_W - 1) - cfg.len_m1);
    assign tick      = (st == ENG_RUN) && (cnt == div);
    assign leading   = ~eidx[0];
    assign last_edge = (eidx == {len_q, 1'b1});
    assign smp_edge  = late_q ? ~leading : leading;

    assign busy    = (st == ENG_RUN);
    assign rx_word = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ENG_IDLE;
            cnt    <= '0;
            eidx   <= '0;
            len_q  <= '0;
            late_q <= 1'b0;
            sh     <= '0;
            rx_q   <= '0;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == ENG_IDLE) begin
                if (start) begin
                    st     <= ENG_RUN;
                    cnt    <= '0;
                    eidx   <= '0;
                    len_q  <= cfg.len_m1;
                    late_q <= cfg.late_smp;
                    sclk   <= cfg.idle_hi;
                    rx_q   <= '0;
                    if (cfg.late_smp) begin
                        mosi <= 1'b0;
                        sh   <= aligned;
                    end else begin
                        mosi <= aligned[WORD_W-1];
                        sh   <= aligned << 1;
                    end
                end
            end else if (tick) begin
                cnt  <= '0;
                eidx <= eidx + 1'b1;
                sclk <= ~sclk;
                if (smp_edge) begin
                    rx_q <= {rx_q[WORD_W-2:0], miso};
                end else if (!last_edge) begin
                    mosi <= sh[WORD_W-1];
                    sh   <= sh << 1;
                end
                if (last_edge) begin
                    st   <= ENG_IDLE;
                    done <= 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
    import spiflash_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    ctrl_t             ctrl_q, ctrl_new;
    logic              hit_ctrl, hit_stat, hit_txd, hit_rxd;
    logic              wr_ctrl, wr_stat, wr_txd, rd_rxd;
    logic              eng_busy, eng_done, start;
    logic              ready_q, under_q, over_q, keep_rx_q;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_pop, rx_push;
    logic [WORD_W-1:0] tx_head, rx_head, eng_rx, eng_tx;
    logic [WORD_W-1:0] stat_word, rd_mux;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign hit_txd  = (bus_addr == ADDR_W'(OFS_TXD));
    assign hit_rxd  = (bus_addr == ADDR_W'(OFS_RXD));

    assign wr_ctrl = bus_wr && hit_ctrl;
    assign wr_stat = bus_wr && hit_stat;
    assign wr_txd  = bus_wr && hit_txd;
    assign rd_rxd  = bus_rd && hit_rxd;

    assign ctrl_new = ctrl_unpack(bus_wdata);
    assign start    = wr_ctrl && bus_wdata[C_START] && !eng_busy;
    assign tx_pop   = start && ctrl_new.tx_on && !tx_empty;
    assign eng_tx   = (ctrl_new.tx_on && !tx_empty) ? tx_head : '0;
    assign rx_push  = eng_done && keep_rx_q;

    spiflash_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (wr_stat && bus_wdata[S_TXDROP]),
        .push  (wr_txd),
        .wdata (bus_wdata),
        .pop   (tx_pop),
        .rdata (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spiflash_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (wr_stat && bus_wdata[S_RXDROP]),
        .push  (rx_push),
        .wdata (eng_rx),
        .pop   (rd_rxd),
        .rdata (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    spiflash_shifter #(.DIV_W(DIV_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .div     (div),
        .start   (start),
        .cfg     (ctrl_new),
        .tx_word (eng_tx),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_word (eng_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            ready_q   <= 1'b0;
            under_q   <= 1'b0;
            over_q    <= 1'b0;
            keep_rx_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_new;
            if (start)   keep_rx_q <= ctrl_new.rx_on;

            if (eng_done)                          ready_q <= 1'b1;
            else if (wr_stat && bus_wdata[S_DONE]) ready_q <= 1'b0;

            if (wr_txd && tx_full)                  over_q <= 1'b1;
            else if (wr_stat && bus_wdata[S_OVER])  over_q <= 1'b0;

            if (rd_rxd && rx_empty)                 under_q <= 1'b1;
            else if (wr_stat && bus_wdata[S_UNDER]) under_q <= 1'b0;
        end
    end

    always_comb begin
        stat_word          = '0;
        stat_word[S_BUSY]  = eng_busy;
        stat_word[S_DONE]  = ready_q;
        stat_word[S_UNDER] = under_q;
        stat_word[S_OVER]  = over_q;
        stat_word[S_RXEMP] = rx_empty;
        stat_word[S_RXFUL] = rx_full;
        stat_word[S_TXEMP] = tx_empty;
        stat_word[S_TXFUL] = tx_full;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)      rd_mux = ctrl_pack(ctrl_q);
        else if (hit_stat) rd_mux = stat_word;
        else if (hit_rxd)  rd_mux = rx_empty ? '0 : rx_head;
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign cs_n = ctrl_q.cs_man ? ~ctrl_q.cs_lvl : ~eng_busy;

endmodule

// File: rtl/spiflash_chk.sv
module spiflash_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              ready,
    input logic              sclk,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              over,
    input logic              under,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr
);
    // R8
    ready_from_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(done));

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R4
    sclk_quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(sclk));

    // R11
    txq_levels_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty));

    // R11
    rxq_levels_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty));

    // R9
    over_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(8'h10) && tx_full) |=> over);

    // R9
    under_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(8'h20) && rx_empty) |=> under);
endmodule

bind spi_flash_master spiflash_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (eng_busy),
    .done     (eng_done),
    .ready    (ready_q),
    .sclk     (sclk),
    .tx_full  (tx_full),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .rx_empty (rx_empty),
    .over     (over_q),
    .under    (under_q),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr)
);

// File: tb/spi_flash_master_tb.sv
module spi_flash_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A_CTRL = 6'h00;
    localparam logic [5:0] A_STAT = 6'h04;
    localparam logic [5:0] A_TXD  = 6'h10;
    localparam logic [5:0] A_RXD  = 6'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  div = 8'd1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso, cs_n;
    logic [1:0]  miso_sel = 2'd0;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    assign miso = (miso_sel == 2'd0) ? mosi : (miso_sel == 2'd1);

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_master u_dut (
        .clk(clk), .rst(rst), .div(div),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mask_n(input int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return m[31:0];
    endfunction

    function automatic logic [31:0] mk_ctrl(input int n, input bit pha, input bit pol,
                                           input bit txe, input bit rxe, input bit man,
                                           input bit lvl, input bit go);
        logic [31:0] w;
        w = 32'(n - 1) & 32'h1f;
        w[18] = pha; w[26] = pol; w[15] = txe; w[14] = rxe;
        w[12] = man; w[13] = lvl; w[30] = go;
        return w;
    endfunction

    function automatic logic [31:0] exp_rx(input int n, input logic [31:0] word,
                                          input bit txe, input logic [1:0] sel);
        if (sel == 2'd1) return mask_n(n);
        if (sel == 2'd2) return 32'd0;
        return txe ? (word & mask_n(n)) : 32'd0;
    endfunction

    // one transfer, checked on the pins and through the registers
    task automatic xfer(input int n, input logic [31:0] word, input bit pha, input bit pol,
                        input bit txe, input bit rxe, input bit man, input logic [1:0] sel,
                        input bit rd_back);
        int          toggles = 0, last_k = 0, span;
        logic        prev;
        logic [31:0] d;
        span = 2 * n * (int'(div) + 1);
        miso_sel = sel;
        if (txe) wr(A_TXD, word);
        wr(A_CTRL, mk_ctrl(n, pha, pol, txe, rxe, man, 1'b0, 1'b1));
        chk("R4 idle level at start", {31'd0, sclk}, {31'd0, pol});
        if (txe && !pha) chk("R3 first bit before first edge", {31'd0, mosi}, {31'd0, word[n-1]});
        if (pha) chk("R4 mosi held before first edge", {31'd0, mosi}, 32'd0);
        prev = sclk;
        for (int k = 1; k <= span + 3; k++) begin
            @(negedge clk);
            if (sclk !== prev) begin toggles++; last_k = k; end
            prev = sclk;
            if (k == 1 && !man) chk("R7 cs follows transfer", {31'd0, cs_n}, 32'd0);
            if (k == int'(div) + 1 && pha && txe)
                chk("R4 first bit on first edge", {31'd0, mosi}, {31'd0, word[n-1]});
        end
        chk("R2 edge count", 32'(toggles), 32'(2 * n));
        chk("R2 last edge cycle", 32'(last_k), 32'(span));
        chk("R4 idle level after", {31'd0, sclk}, {31'd0, pol});
        if (!man) chk("R7 cs released", {31'd0, cs_n}, 32'd1);
        rd(A_STAT, d);
        chk("R8 busy clear", {31'd0, d[31]}, 32'd0);
        chk("R8 ready set", {31'd0, d[30]}, 32'd1);
        rd(A_STAT, d);
        chk("R8 ready sticky", {31'd0, d[30]}, 32'd1);
        wr(A_STAT, 32'h4000_0000);
        rd(A_STAT, d);
        chk("R8 ready cleared", {31'd0, d[30]}, 32'd0);
        if (rd_back) begin
            if (rxe) begin
                rd(A_RXD, d);
                chk("R3 received word", d, exp_rx(n, word, txe, sel));
            end else begin
                rd(A_STAT, d);
                chk("R6 nothing pushed", {31'd0, d[25]}, 32'd1);
            end
        end
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h0005_eed1));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);
        chk("R1 mosi", {31'd0, mosi}, 32'd0);
        rd(A_STAT, d);
        chk("R1 status", d, 32'h0280_0000);
        rd(A_CTRL, d);
        chk("R1 control", d, 32'd0);

        // R12 control readback, one cycle read latency
        wr(A_CTRL, mk_ctrl(8, 1, 1, 1, 0, 0, 0, 0));
        rd(A_CTRL, d);
        chk("R12 control readback", d, 32'h0404_8007);

        // R2/R3 length corners
        div = 8'd0;
        xfer(1, 32'h0000_0001, 0, 0, 1, 1, 0, 2'd0, 1);
        xfer(32, 32'hC35A_9617, 0, 0, 1, 1, 0, 2'd0, 1);
        div = 8'd2;
        xfer(8, 32'hFFFF_FFA5, 1, 1, 1, 1, 0, 2'd0, 1);
        xfer(12, 32'h0000_0000, 0, 1, 1, 1, 0, 2'd1, 1);

        // R5 start while running is ignored
        div = 8'd3;
        miso_sel = 2'd0;
        wr(A_TXD, 32'h0000_00C3);
        wr(A_TXD, 32'h0000_003C);
        wr(A_CTRL, mk_ctrl(8, 0, 0, 1, 1, 0, 0, 1));
        wr(A_CTRL, mk_ctrl(8, 0, 0, 1, 1, 0, 0, 1));
        repeat (80) @(negedge clk);
        rd(A_STAT, d);
        chk("R5 second word kept", {31'd0, d[23]}, 32'd0);
        rd(A_RXD, d);
        chk("R5 single result", d, 32'h0000_00C3);
        rd(A_STAT, d);
        chk("R5 one word received", {31'd0, d[25]}, 32'd1);
        wr(A_STAT, 32'h1000_0000);
        rd(A_STAT, d);
        chk("R10 transmit flush", {31'd0, d[23]}, 32'd1);
        wr(A_STAT, 32'h4000_0000);

        // R6 transmit disabled: zeros out, queue untouched
        div = 8'd1;
        wr(A_TXD, 32'hFFFF_FFFF);
        xfer(16, 32'hFFFF_FFFF, 0, 0, 0, 1, 0, 2'd0, 1);
        rd(A_STAT, d);
        chk("R6 queue not popped", {31'd0, d[23]}, 32'd0);
        wr(A_STAT, 32'h1000_0000);
        // R6 receive disabled
        xfer(8, 32'h0000_0055, 0, 0, 1, 0, 0, 2'd0, 1);

        // R7 manual chip select
        wr(A_CTRL, mk_ctrl(8, 0, 0, 1, 1, 1, 1, 0));
        @(negedge clk);
        chk("R7 manual assert", {31'd0, cs_n}, 32'd0);
        xfer(8, 32'h0000_0081, 0, 0, 1, 1, 1, 2'd0, 1);
        wr(A_CTRL, mk_ctrl(8, 0, 0, 1, 1, 1, 0, 0));
        @(negedge clk);
        chk("R7 manual release", {31'd0, cs_n}, 32'd1);
        wr(A_CTRL, 32'd0);

        // R9/R11 transmit overflow
        for (int i = 0; i < 4; i++) wr(A_TXD, 32'(i));
        rd(A_STAT, d);
        chk("R11 transmit full", {30'd0, d[23:22]}, 32'd1);
        chk("R9 no overflow yet", {31'd0, d[26]}, 32'd0);
        wr(A_TXD, 32'hDEAD_BEEF);
        rd(A_STAT, d);
        chk("R9 overflow set", {31'd0, d[26]}, 32'd1);
        wr(A_STAT, 32'h0400_0000);
        rd(A_STAT, d);
        chk("R9 overflow cleared", {31'd0, d[26]}, 32'd0);
        xfer(32, 32'd0, 0, 0, 1, 1, 0, 2'd0, 0);
        rd(A_RXD, d);
        chk("R9 dropped word not sent", d, 32'd0);
        wr(A_STAT, 32'h1000_0000);

        // R9 underrun
        rd(A_RXD, d);
        chk("R9 empty read returns 0", d, 32'd0);
        rd(A_STAT, d);
        chk("R9 underrun set", {31'd0, d[27]}, 32'd1);
        wr(A_STAT, 32'h0800_0000);
        rd(A_STAT, d);
        chk("R9 underrun cleared", {31'd0, d[27]}, 32'd0);

        // R11 receive full, R10 receive flush
        for (int i = 0; i < 4; i++) xfer(8, 32'(i + 1), 0, 0, 1, 1, 0, 2'd0, 0);
        rd(A_STAT, d);
        chk("R11 receive full", {30'd0, d[25:24]}, 32'd1);
        wr(A_STAT, 32'h2000_0000);
        rd(A_STAT, d);
        chk("R10 receive flush", {30'd0, d[25:24]}, 32'd2);

        // random traffic
        for (int i = 0; i < 30; i++) begin
            int          n;
            logic [31:0] w;
            n   = int'($urandom_range(1, 32));
            w   = $urandom;
            div = 8'($urandom_range(0, 3));
            xfer(n, w, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1, 1, 0,
                 2'($urandom_range(0, 2)), 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        finished = 1;
        $finish;
    end
endmodule